// File: doc/BRIEF.md
# Reference-Counted Active Target Mask

This block keeps a registration count for each of a fixed number of targets. It exposes one bit per target that is set while that target has at least one registration. Other logic reads the bitmask to decide which targets to address. Each cycle the block accepts at most one register or unregister strobe, together with a target index.

Besides the per-target bits, the block watches the whole mask. It emits a one-cycle pulse when the mask goes from empty to non-empty, and another when it goes from non-empty to empty. An external agent can use these pulses to raise or drop a global notification.

Any misuse drives a one-cycle error flag: a bad index, an over-count, an under-count, or both strobes at once. The state stays as it was, except that a register strobe that wins a collision is still applied.

Top module: `tgt_refcnt_mask`

## Requirements
- R1: A register strobe on an index whose count is 0 sets that index's mask bit and makes its count 1, visible after the next clock edge.
- R2: A register strobe on an index with a non-zero count below 255 adds 1 to the count and leaves the mask bit set.
- R3: `first_act_o` is high for exactly one cycle, in the cycle after the edge on which the mask goes from all-zero to non-zero. It stays low when a bit is set while another bit is already set.
- R4: An unregister strobe on an index with a non-zero count subtracts 1. The mask bit clears only when the count reaches 0.
- R5: `last_inact_o` is high for exactly one cycle, in the cycle after the edge on which the last set mask bit clears. It stays low when other bits remain set.
- R6: An unregister strobe on an index whose count is 0, or whose mask bit is clear, raises `err_o` and changes no count and no mask bit.
- R7: A strobe whose index is NUM_TGT or above (indices 6 and 7 with defaults) raises `err_o` and changes no count and no mask bit.
- R8: Counts are 8 bits wide. A register strobe on a count of 255 raises `err_o` and leaves the count at 255.
- R9: When both strobes are high in one cycle, the register operation is applied and `err_o` is raised.
- R10: After reset every mask bit, count, pulse and `err_o` is 0. `err_o` is high only in the cycle after an erroneous strobe.
- R11: An operation on one index leaves the counts and mask bits of all other indices unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_i | input | 1 | Register strobe |
| unreg_i | input | 1 | Unregister strobe |
| idx_i | input | IDX_W | Target index of the strobe |
| mask_o | output | NUM_TGT | Active bit per target, bit i for index i |
| cnt_o | output | NUM_TGT*CNT_W | Counts, index i at bits [i*CNT_W +: CNT_W] |
| err_o | output | 1 | One-cycle error flag |
| first_act_o | output | 1 | Pulse on the empty to non-empty change of the mask |
| last_inact_o | output | 1 | Pulse on the non-empty to empty change of the mask |

## Verification
The bench uses the default build: six targets, a 3-bit index and 8-bit counts. Because the index is wider than the target count, indices 6 and 7 can be driven, which exercises the out-of-range error path. The 8-bit counter limit lets one index be walked to 255 and pushed once more in a few hundred cycles, so saturation is observed directly. Two indices are held active at once to show that neither global pulse fires while the other bit stays set.

// File: rtl/tgt_mask_pkg.sv
package tgt_mask_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } slot_op_e;
endpackage

// File: rtl/tgt_rst_sync.sv
module tgt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tgt_ref_slot.sv
module tgt_ref_slot
  import tgt_mask_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_op_e         cmd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             en;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    en    = (cmd_i != OP_NONE);
    unique case (cmd_i)
      OP_INC: begin
        cnt_d = cnt_q + 1'b1;
        act_d = 1'b1;
      end
      OP_DEC: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) act_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/tgt_op_decode.sv
module tgt_op_decode
  import tgt_mask_pkg::*;
#(
  parameter int NUM_TGT = 6,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 8
) (
  input  logic             reg_i,
  input  logic             unreg_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i [NUM_TGT],
  input  logic             act_i [NUM_TGT],
  output slot_op_e         cmd_o [NUM_TGT],
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             in_rng;
  logic [CNT_W-1:0] hit_cnt;
  logic             hit_act;
  slot_op_e         sel_op;

  // Select the addressed slot without indexing beyond the array.
  always_comb begin
    in_rng  = 1'b0;
    hit_cnt = '0;
    hit_act = 1'b0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (idx_i == IDX_W'(i)) begin
        in_rng  = 1'b1;
        hit_cnt = cnt_i[i];
        hit_act = act_i[i];
      end
    end
  end

  always_comb begin
    err_o  = 1'b0;
    sel_op = OP_NONE;
    if (reg_i) begin
      if (unreg_i) err_o = 1'b1;
      if (!in_rng) begin
        err_o = 1'b1;
      end else if (hit_cnt == CNT_MAX) begin
        err_o = 1'b1;
      end else begin
        // a live count with a clear bit is an inconsistency
        if (hit_cnt != '0 && !hit_act) err_o = 1'b1;
        sel_op = OP_INC;
      end
    end else if (unreg_i) begin
      if (!in_rng || hit_cnt == '0 || !hit_act) err_o = 1'b1;
      else                                      sel_op = OP_DEC;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_cmd
    assign cmd_o[g] = (in_rng && idx_i == IDX_W'(g)) ? sel_op : OP_NONE;
  end
endmodule

// File: rtl/tgt_mask_edge.sv
module tgt_mask_edge #(
  parameter int NUM_TGT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TGT-1:0] mask_i,
  output logic               first_o,
  output logic               last_o
);
  logic any_now, any_q, any_en;

  assign any_now = |mask_i;
  assign any_en  = (any_now != any_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      any_q <= 1'b0;
    else if (any_en) any_q <= any_now;
  end

  assign first_o = any_now & ~any_q;
  assign last_o  = ~any_now & any_q;
endmodule

// File: rtl/tgt_refcnt_mask.sv
module tgt_refcnt_mask
  import tgt_mask_pkg::*;
#(
  parameter int NUM_TGT = 6,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_i,
  input  logic                     unreg_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [NUM_TGT-1:0]       mask_o,
  output logic [NUM_TGT*CNT_W-1:0] cnt_o,
  output logic                     err_o,
  output logic                     first_act_o,
  output logic                     last_inact_o
);
  logic             rst_sync_n;
  slot_op_e         cmd   [NUM_TGT];
  logic [CNT_W-1:0] cnt_a [NUM_TGT];
  logic             act_a [NUM_TGT];
  logic             err_d, err_q;

  tgt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tgt_op_decode #(
    .NUM_TGT (NUM_TGT),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_dec (
    .reg_i   (reg_i),
    .unreg_i (unreg_i),
    .idx_i   (idx_i),
    .cnt_i   (cnt_a),
    .act_i   (act_a),
    .cmd_o   (cmd),
    .err_o   (err_d)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
    tgt_ref_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .cmd_i (cmd[g]),
      .cnt_o (cnt_a[g]),
      .act_o (act_a[g])
    );
    assign mask_o[g]                 = act_a[g];
    assign cnt_o[g*CNT_W +: CNT_W]   = cnt_a[g];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end
  assign err_o = err_q;

  tgt_mask_edge #(.NUM_TGT(NUM_TGT)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mask_i  (mask_o),
    .first_o (first_act_o),
    .last_o  (last_inact_o)
  );
endmodule

// File: rtl/tgt_refcnt_mask_chk.sv
module tgt_refcnt_mask_chk #(
  parameter int NUM_TGT = 6,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_i,
  input logic                     unreg_i,
  input logic [IDX_W-1:0]         idx_i,
  input logic [NUM_TGT-1:0]       mask_o,
  input logic [NUM_TGT*CNT_W-1:0] cnt_o,
  input logic                     err_o,
  input logic                     first_act_o,
  input logic                     last_inact_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic oor;
  assign oor = (int'(idx_i) >= NUM_TGT);

  AST_FIRST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    first_act_o |-> ($countones(mask_o) == 1)) else $error("first pulse"); // R3
  AST_LAST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    last_inact_o |-> (mask_o == '0)) else $error("last pulse"); // R5
  AST_BOTH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_i && unreg_i) |=> err_o) else $error("both strobes"); // R9
  AST_OOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_i || unreg_i) && oor) |=> (err_o && $stable(mask_o) && $stable(cnt_o))) else $error("oor"); // R7

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot_chk
    AST_REG_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_i && idx_i == IDX_W'(g) && cnt_o[g*CNT_W +: CNT_W] != CNT_MAX)
      |=> (cnt_o[g*CNT_W +: CNT_W] == $past(cnt_o[g*CNT_W +: CNT_W]) + 1'b1) && mask_o[g]) else $error("inc"); // R2
    AST_UNREG_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (unreg_i && !reg_i && idx_i == IDX_W'(g) && cnt_o[g*CNT_W +: CNT_W] != '0)
      |=> (cnt_o[g*CNT_W +: CNT_W] == $past(cnt_o[g*CNT_W +: CNT_W]) - 1'b1)) else $error("dec"); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_i && idx_i == IDX_W'(g) && cnt_o[g*CNT_W +: CNT_W] == CNT_MAX)
      |=> (err_o && cnt_o[g*CNT_W +: CNT_W] == CNT_MAX)) else $error("overflow"); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (unreg_i && !reg_i && idx_i == IDX_W'(g) && cnt_o[g*CNT_W +: CNT_W] == '0)
      |=> (err_o && cnt_o[g*CNT_W +: CNT_W] == '0 && !mask_o[g])) else $error("underflow"); // R6
  end
endmodule

bind tgt_refcnt_mask tgt_refcnt_mask_chk #(
  .NUM_TGT (NUM_TGT),
  .IDX_W   (IDX_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .reg_i        (reg_i),
  .unreg_i      (unreg_i),
  .idx_i        (idx_i),
  .mask_o       (mask_o),
  .cnt_o        (cnt_o),
  .err_o        (err_o),
  .first_act_o  (first_act_o),
  .last_inact_o (last_inact_o)
);

// File: tb/sim_tgt_refcnt_mask.sv
`timescale 1ns/1ps
module sim_tgt_refcnt_mask;
  localparam int NT = 6;
  localparam int IW = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_s, unreg_s;
  logic [IW-1:0] idx_s;
  logic [NT-1:0] mask;
  logic [NT*CW-1:0] cnt;
  logic          err, first_p, last_p;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tgt_refcnt_mask #(.NUM_TGT(NT), .IDX_W(IW), .CNT_W(CW)) u0 (
    .clk (clk), .rst_n (rst_n), .reg_i (reg_s), .unreg_i (unreg_s), .idx_i (idx_s),
    .mask_o (mask), .cnt_o (cnt), .err_o (err),
    .first_act_o (first_p), .last_inact_o (last_p)
  );

  function automatic int cnt_of(input int i);
    return int'(cnt[i*CW +: CW]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One strobe cycle; returns at the negedge after the capturing edge.
  task automatic op(input logic r, input logic u, input int ix);
    @(negedge clk);
    reg_s = r; unreg_s = u; idx_s = IW'(ix);
    @(negedge clk);
    reg_s = 1'b0; unreg_s = 1'b0; idx_s = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "mask", int'(mask), 0);
    chk("R10", "cnt", (cnt == '0) ? 0 : 1, 0);
    chk("R10", "err", int'(err), 0);
    chk("R10", "first", int'(first_p), 0);
    chk("R10", "last", int'(last_p), 0);
  endtask

  task automatic t_first_reg();
    op(1, 0, 2);
    chk("R1", "mask", int'(mask), 6'b000100);
    chk("R1", "cnt2", cnt_of(2), 1);
    chk("R3", "first", int'(first_p), 1);
    chk("R10", "err", int'(err), 0);
    idle();
    chk("R3", "first one cycle", int'(first_p), 0);
  endtask

  task automatic t_more_reg();
    op(1, 0, 2);
    chk("R2", "cnt2", cnt_of(2), 2);
    chk("R2", "mask", int'(mask), 6'b000100);
    op(1, 0, 5);
    chk("R3", "first while nonempty", int'(first_p), 0);
    chk("R11", "mask", int'(mask), 6'b100100);
    chk("R11", "cnt5", cnt_of(5), 1);
    chk("R11", "cnt2 kept", cnt_of(2), 2);
  endtask

  task automatic t_unreg();
    op(0, 1, 2);
    chk("R4", "cnt2", cnt_of(2), 1);
    chk("R4", "mask kept", int'(mask), 6'b100100);
    op(0, 1, 2);
    chk("R4", "mask cleared", int'(mask), 6'b100000);
    chk("R5", "last while nonempty", int'(last_p), 0);
    op(0, 1, 5);
    chk("R5", "mask empty", int'(mask), 0);
    chk("R5", "last", int'(last_p), 1);
    idle();
    chk("R5", "last one cycle", int'(last_p), 0);
  endtask

  task automatic t_unreg_zero();
    op(0, 1, 3);
    chk("R6", "err", int'(err), 1);
    chk("R6", "mask", int'(mask), 0);
    chk("R6", "cnt3", cnt_of(3), 0);
    chk("R6", "last", int'(last_p), 0);
    idle();
    chk("R10", "err clears", int'(err), 0);
  endtask

  task automatic t_out_of_range();
    op(1, 0, 6);
    chk("R7", "err reg", int'(err), 1);
    chk("R7", "mask", int'(mask), 0);
    chk("R7", "cnt", (cnt == '0) ? 0 : 1, 0);
    chk("R7", "first", int'(first_p), 0);
    op(0, 1, 7);
    chk("R7", "err unreg", int'(err), 1);
    chk("R7", "mask after unreg", int'(mask), 0);
  endtask

  task automatic t_both();
    op(1, 1, 1);
    chk("R9", "err", int'(err), 1);
    chk("R9", "cnt1", cnt_of(1), 1);
    chk("R9", "mask", int'(mask), 6'b000010);
    chk("R9", "first", int'(first_p), 1);
    op(0, 1, 1);
    chk("R9", "cleanup err", int'(err), 0);
    chk("R5", "last after cleanup", int'(last_p), 1);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 255; k++) op(1, 0, 0);
    chk("R8", "cnt0 at max", cnt_of(0), 255);
    chk("R8", "no err at max", int'(err), 0);
    op(1, 0, 0);
    chk("R8", "err on overflow", int'(err), 1);
    chk("R8", "cnt0 held", cnt_of(0), 255);
    chk("R8", "mask", int'(mask), 6'b000001);
    for (int k = 0; k < 255; k++) op(0, 1, 0);
    chk("R4", "cnt0 drained", cnt_of(0), 0);
    chk("R5", "last after drain", int'(last_p), 1);
    chk("R11", "others untouched", (cnt == '0) ? 0 : 1, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_s = 1'b0; unreg_s = 1'b0; idx_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_reg();
    t_more_reg();
    t_unreg();
    t_unreg_zero();
    t_out_of_range();
    t_both();
    t_saturate();
    finish_run();
  end
endmodule